// File: doc/BRIEF.md
# JTAG-to-SPI Flash Bridge

This block sits behind a user instruction of a JTAG TAP and turns data-register shift traffic into serial-flash SPI transactions. It is clocked by TCK and receives the TAP's select, capture, shift and update strobes together with TDI. It returns TDO, drives the SPI clock, chip select and MOSI, and samples MISO. Its data register is a single bit. Any number of BYPASSed TAPs may therefore sit on either side of it, and the host never has to tell the bridge how long the chain is.

Each frame describes itself. While shifting, the bridge discards zeros until it sees the first one. That one is a start marker. It is followed by a bit count that is LEN_W bits wide and sent most significant bit first. The bridge then runs exactly that many SPI clocks with chip select low. Each SPI clock is one TCK high phase: TDI goes straight to MOSI, and MISO is captured into the one-bit register that feeds TDO. After the count runs out, the bridge keeps shifting as a plain one-bit delay, so the returned flash data can drain through downstream bypass registers.

Dropping the shift strobe, deselecting the instruction, or pulsing capture or update always sends the bridge back to marker hunting. Any transfer in progress is abandoned.

Top module: `jtag_spi_bridge`

## Requirements
- R1: While reset is applied and after it is released, spi_cs_n is 1, spi_sck is 0, spi_mosi is 0 and tdo is 0.
- R2: While hunting for a marker, shifted 0 bits start no transaction: spi_cs_n stays 1 and no SPI clock pulse occurs.
- R3: Outside the payload phase, tdo after each active shift edge equals the tdi value sampled at that edge (a one-bit data register).
- R4: The first 1 bit shifted while hunting is the start marker. The next LEN_W bits (32 by default) form the transfer length, most significant bit first.
- R5: spi_cs_n falls on the TCK falling edge after the last length bit. It rises on the TCK falling edge after the L-th payload edge. Exactly L SPI clock pulses occur, each one a TCK high phase, and none occurs while spi_cs_n is 1.
- R6: During the payload phase spi_mosi follows tdi, so the flash sees the payload bits in shift order on SPI clock rising edges.
- R7: During the payload phase, tdo after each payload edge equals the spi_miso value sampled at that edge.
- R8: After the counted payload, further shift cycles produce no SPI clock, keep spi_cs_n at 1, and loop tdi to tdo.
- R9: A transfer length of 0 completes with spi_cs_n never asserted and no SPI clock pulse.
- R10: A TCK rising edge with shift low outside the hunting state aborts the frame. The length counter is cleared, no SPI clock pulse occurs on that edge, and spi_cs_n returns to 1 on the next falling edge.
- R11: A capture pulse, an update pulse or sel low returns the bridge to marker hunting, abandoning any partial header or payload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | TAP test clock |
| trst_n | input | 1 | Asynchronous active-low reset, released synchronously to tck |
| sel | input | 1 | High while the bridge instruction is in the TAP instruction register |
| capture | input | 1 | Capture-DR strobe |
| shift | input | 1 | Shift-DR strobe |
| update | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data from the TAP |
| tdo | output | 1 | Serial data to the TAP (one-bit register) |
| spi_sck | output | 1 | SPI clock, TCK gated during the payload phase |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
The hardest situations to reach from the ports are the mid-frame exits. These are a shift strobe dropped partway through the payload, the instruction deselected while chip select is low, and a capture arriving in the middle of the length header. Each one must leave the length counter clean for the next frame. The directed tasks reach them by sending a real header and then cutting the frame after a chosen number of payload edges. The tasks then count SPI clock pulses and chip-select falls with edge monitors and send a fresh short frame, whose pulse count shows whether stale count or header bits survived. A length of 37, which reads as a very large count if taken least significant bit first, exposes a bit-order error through surplus pulses during the drain cycles.

// File: rtl/jspi_pkg.sv
package jspi_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_HDR   = 2'd1,
    ST_XFER  = 2'd2,
    ST_DRAIN = 2'd3
  } jspi_state_e;

endpackage

// File: rtl/jspi_frame_fsm.sv
module jspi_frame_fsm
  import jspi_pkg::*;
#(
  parameter int unsigned LEN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              tdi,
  output jspi_state_e       state,
  output logic [LEN_W-1:0]  cnt
);

  localparam int unsigned HC_W = (LEN_W > 1) ? $clog2(LEN_W) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(LEN_W - 1);

  jspi_state_e      state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [HC_W-1:0]  hc_q, hc_d;
  logic [LEN_W-1:0] hdr_shifted;
  logic             hdr_last;
  logic             regs_en;

  assign hdr_shifted = {cnt_q[LEN_W-2:0], tdi};
  assign hdr_last    = (hc_q == HC_LAST);
  // registers only move when shifting or when a frame must be abandoned
  assign regs_en     = active || (state_q != ST_HUNT);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    hc_d    = hc_q;
    if (!active) begin
      state_d = ST_HUNT;
      cnt_d   = '0;
      hc_d    = '0;
    end else begin
      unique case (state_q)
        ST_HUNT: begin
          if (tdi) begin
            state_d = ST_HDR;
            cnt_d   = '0;
            hc_d    = '0;
          end
        end
        ST_HDR: begin
          cnt_d = hdr_shifted;
          hc_d  = hc_q + HC_W'(1);
          if (hdr_last) begin
            hc_d    = '0;
            state_d = (hdr_shifted == '0) ? ST_DRAIN : ST_XFER;
          end
        end
        ST_XFER: begin
          cnt_d = cnt_q - LEN_W'(1);
          if (cnt_q == LEN_W'(1)) begin
            state_d = ST_DRAIN;
          end
        end
        default: begin
          state_d = ST_DRAIN;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      hc_q    <= '0;
    end else if (regs_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hc_q    <= hc_d;
    end
  end

  assign state = state_q;
  assign cnt   = cnt_q;

endmodule

// File: rtl/jspi_spi_gate.sv
module jspi_spi_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic in_xfer,
  input  logic active,
  input  logic tdi,
  output logic spi_sck,
  output logic spi_cs_n,
  output logic spi_mosi
);

  logic gate_q;

  // updated while TCK is low so that the gated clock never glitches
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= in_xfer;
    end
  end

  assign spi_sck  = clk & gate_q & active;
  assign spi_cs_n = ~gate_q;
  assign spi_mosi = gate_q & tdi;

endmodule

// File: rtl/jspi_dr_cell.sv
module jspi_dr_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic active,
  input  logic in_xfer,
  input  logic tdi,
  input  logic spi_miso,
  output logic tdo
);

  logic dr_q, dr_d, dr_en;

  assign dr_en = clear | active;
  assign dr_d  = clear ? 1'b0 : (in_xfer ? spi_miso : tdi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q <= 1'b0;
    end else if (dr_en) begin
      dr_q <= dr_d;
    end
  end

  assign tdo = dr_q;

endmodule

// File: rtl/jtag_spi_bridge.sv
module jtag_spi_bridge
  import jspi_pkg::*;
#(
  parameter int unsigned LEN_W = 32
) (
  input  logic tck,
  input  logic trst_n,
  input  logic sel,
  input  logic capture,
  input  logic shift,
  input  logic update,
  input  logic tdi,
  output logic tdo,
  output logic spi_sck,
  output logic spi_cs_n,
  output logic spi_mosi,
  input  logic spi_miso
);

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             active;
  logic             in_xfer;
  jspi_state_e      fsm_state;
  logic [LEN_W-1:0] fsm_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  assign active  = sel & shift & ~capture & ~update;
  assign in_xfer = (fsm_state == ST_XFER);

  jspi_frame_fsm #(.LEN_W(LEN_W)) i_fsm (
    .clk    (tck),
    .rst_n  (rst_n),
    .active (active),
    .tdi    (tdi),
    .state  (fsm_state),
    .cnt    (fsm_cnt)
  );

  jspi_spi_gate i_gate (
    .clk      (tck),
    .rst_n    (rst_n),
    .in_xfer  (in_xfer),
    .active   (active),
    .tdi      (tdi),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi)
  );

  jspi_dr_cell i_dr (
    .clk      (tck),
    .rst_n    (rst_n),
    .clear    (sel & capture),
    .active   (active),
    .in_xfer  (in_xfer),
    .tdi      (tdi),
    .spi_miso (spi_miso),
    .tdo      (tdo)
  );

endmodule

// File: rtl/jtag_spi_bridge_chk.sv
module jtag_spi_bridge_chk
  import jspi_pkg::*;
#(
  parameter int unsigned LEN_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             capture,
  input logic             shift,
  input logic             update,
  input logic             tdi,
  input logic             spi_miso,
  input logic             tdo,
  input logic             spi_sck,
  input logic             spi_cs_n,
  input jspi_state_e      state,
  input logic [LEN_W-1:0] cnt
);

  logic act;
  assign act = sel & shift & ~capture & ~update;

  // R5: every SPI clock pulse lies inside chip select
  always @(posedge spi_sck) begin
    if (rst_n) begin
      p_sck_in_frame_r5: assert (!spi_cs_n);
    end
  end

  p_zero_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT && act && !tdi) |=> (state == ST_HUNT));

  p_marker_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT && act && tdi) |=> (state == ST_HDR));

  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XFER && act && cnt > LEN_W'(1)) |=>
      (state == ST_XFER && cnt == $past(cnt) - LEN_W'(1)));

  p_loopback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act && state != ST_XFER) |=> (tdo == $past(tdi)));

  p_miso_to_tdo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act && state == ST_XFER) |=> (tdo == $past(spi_miso)));

  p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_HUNT && sel && !shift && !capture && !update) |=>
      (state == ST_HUNT && cnt == '0));

  p_reselect_hunt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (capture || update || !sel) |=> (state == ST_HUNT));

endmodule

bind jtag_spi_bridge jtag_spi_bridge_chk #(.LEN_W(LEN_W)) i_chk (
  .clk      (tck),
  .rst_n    (rst_n),
  .sel      (sel),
  .capture  (capture),
  .shift    (shift),
  .update   (update),
  .tdi      (tdi),
  .spi_miso (spi_miso),
  .tdo      (tdo),
  .spi_sck  (spi_sck),
  .spi_cs_n (spi_cs_n),
  .state    (fsm_state),
  .cnt      (fsm_cnt)
);

// File: tb/test_jtag_spi_bridge.sv
`timescale 1ns/1ps
module test_jtag_spi_bridge;

  logic tck, trst_n, sel, capture, shift, update, tdi, spi_miso;
  logic tdo, spi_sck, spi_cs_n, spi_mosi;

  int checks = 0;
  int fails  = 0;
  int sck_cnt = 0;
  int cs_fall_cnt = 0;
  int sck_outside = 0;
  logic [63:0] mosi_log = '0;

  jtag_spi_bridge i_jtag_spi_bridge (
    .tck(tck), .trst_n(trst_n), .sel(sel), .capture(capture),
    .shift(shift), .update(update), .tdi(tdi), .tdo(tdo),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  initial begin
    tck = 1'b0;
    forever #2.5 tck = ~tck;
  end

  always @(posedge spi_sck) begin
    sck_cnt = sck_cnt + 1;
    mosi_log = {mosi_log[62:0], spi_mosi};
    if (spi_cs_n) sck_outside = sck_outside + 1;
  end

  always @(negedge spi_cs_n) cs_fall_cnt = cs_fall_cnt + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic m, input logic sh);
    @(negedge tck);
    tdi = b; spi_miso = m; shift = sh; capture = 1'b0; update = 1'b0; sel = 1'b1;
    @(posedge tck);
    #1;
  endtask

  task automatic reselect();
    @(negedge tck);
    sel = 1'b1; capture = 1'b1; shift = 1'b0; update = 1'b0; tdi = 1'b0;
    @(posedge tck);
    #1;
  endtask

  task automatic send_header(input int unsigned len);
    step(1'b1, 1'b0, 1'b1);
    chk(tdo == 1'b1, "R3", tdo, 1);
    for (int i = 31; i >= 0; i--) begin
      step(len[i], 1'b0, 1'b1);
      chk(tdo == len[i], "R3", tdo, len[i]);
    end
    chk(spi_cs_n == 1'b1, "R4", spi_cs_n, 1);
  endtask

  task automatic t_frame(input int len, input int nlead, input logic [63:0] mp,
                         input logic [63:0] sp, input bit do_sel, input string cnt_req);
    int s0, f0;
    logic [63:0] exp_log, mask;
    if (do_sel) reselect();
    repeat (nlead) step(1'b0, 1'b0, 1'b1);
    s0 = sck_cnt;
    f0 = cs_fall_cnt;
    send_header(len);
    for (int i = 0; i < len; i++) begin
      step(mp[i], sp[i], 1'b1);
      chk(spi_cs_n == 1'b0, "R5", spi_cs_n, 0);
      chk(tdo == sp[i], "R7", tdo, sp[i]);
    end
    chk(sck_cnt - s0 == len, cnt_req, sck_cnt - s0, len);
    if (len > 0) begin
      exp_log = '0;
      for (int i = 0; i < len; i++) exp_log[len-1-i] = mp[i];
      mask = (64'h1 << len) - 64'h1;
      chk((mosi_log & mask) == exp_log, "R6", mosi_log & mask, exp_log);
    end
    for (int i = 0; i < 6; i++) begin
      step(i[0], 1'b1, 1'b1);
      chk(spi_cs_n == 1'b1, "R8", spi_cs_n, 1);
      chk(tdo == i[0], "R8", tdo, i[0]);
    end
    chk(sck_cnt - s0 == len, "R8", sck_cnt - s0, len);
    if (len > 0) chk(cs_fall_cnt - f0 == 1, "R5", cs_fall_cnt - f0, 1);
    else         chk(cs_fall_cnt - f0 == 0, "R9", cs_fall_cnt - f0, 0);
  endtask

  task automatic t_reset();
    chk(spi_cs_n == 1'b1, "R1", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R1", spi_sck, 0);
    chk(spi_mosi == 1'b0, "R1", spi_mosi, 0);
    chk(tdo == 1'b0, "R1", tdo, 0);
  endtask

  task automatic t_zeros();
    int s0, f0;
    reselect();
    s0 = sck_cnt; f0 = cs_fall_cnt;
    for (int i = 0; i < 12; i++) begin
      step(1'b0, 1'b1, 1'b1);
      chk(spi_cs_n == 1'b1, "R2", spi_cs_n, 1);
    end
    chk(cs_fall_cnt == f0, "R2", cs_fall_cnt - f0, 0);
    chk(sck_cnt == s0, "R2", sck_cnt - s0, 0);
  endtask

  task automatic t_abort();
    int s0, f0;
    reselect();
    s0 = sck_cnt; f0 = cs_fall_cnt;
    send_header(10);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk(spi_cs_n == 1'b1, "R10", spi_cs_n, 1);
    chk(sck_cnt - s0 == 4, "R10", sck_cnt - s0, 4);
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 1'b1);
    chk(cs_fall_cnt - f0 == 1, "R10", cs_fall_cnt - f0, 1);
    t_frame(2, 3, 64'h2, 64'h1, 1'b0, "R10");
  endtask

  task automatic t_reselect();
    int s0;
    // capture in the middle of the header
    reselect();
    step(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b1);
    t_frame(3, 2, 64'h5, 64'h6, 1'b1, "R11");
    // sel low during payload
    reselect();
    s0 = sck_cnt;
    send_header(20);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1);
    @(negedge tck); sel = 1'b0; shift = 1'b1;
    @(posedge tck); #1;
    @(negedge tck); @(posedge tck); #1;
    chk(spi_cs_n == 1'b1, "R11", spi_cs_n, 1);
    chk(sck_cnt - s0 == 5, "R11", sck_cnt - s0, 5);
    // update pulse during payload
    reselect();
    s0 = sck_cnt;
    send_header(20);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1);
    @(negedge tck); update = 1'b1; shift = 1'b1;
    @(posedge tck); #1;
    step(1'b0, 1'b0, 1'b1);
    chk(spi_cs_n == 1'b1, "R11", spi_cs_n, 1);
    chk(sck_cnt - s0 == 3, "R11", sck_cnt - s0, 3);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    trst_n = 1'b0; sel = 1'b0; capture = 1'b0; shift = 1'b0;
    update = 1'b0; tdi = 1'b0; spi_miso = 1'b0;
    #12;
    t_reset();
    trst_n = 1'b1;
    repeat (3) @(posedge tck);
    #1;
    t_reset();
    t_zeros();
    t_frame(5, 3, 64'h16, 64'h0B, 1'b1, "R5");
    t_frame(37, 7, 64'h1A_5C3E_9F01, 64'h0C_A5F0_3377, 1'b1, "R4");
    t_frame(0, 1, 64'h0, 64'h0, 1'b1, "R9");
    t_abort();
    t_reselect();
    chk(sck_outside == 0, "R5", sck_outside, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule